// File: doc/BRIEF.md
# SPI Serial EEPROM Responder

This block is the slave side of a four-wire serial EEPROM, built as synthesizable logic for emulation and board-level bring-up. It runs from a fast system clock, oversamples the chip-select, serial-clock and serial-in pins, and holds a small byte array in registers. Through that interface a host can latch write permission, read and write the status byte, stream bytes out of the array and program bytes into it.

It enforces the timing rules of a real device rather than acting as a plain shift register. A program instruction is refused if write permission is not latched. It is also refused if it arrives too soon after permission was granted. After a program the block reports busy for a write-cycle time, and during that time it ignores memory and program traffic. A frame whose last clock pulse was not completed before chip-select rose commits nothing. The enable-to-program gap and the write-cycle length are parameters counted in system clocks.

Top module: `spi_eeprom_responder`

## Requirements
- R1: After reset SO is 0, every debug flag is 0, the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Instruction 0x06 sets the write-permission latch. Instruction 0x05 returns the status byte {4'b0, protect[1:0], latch, busy}: bit 0 is busy, bit 1 is the latch and bits 3:2 are the protect bits.
- R3: A program (0x02) or status write (0x01) issued while the latch is clear changes nothing and sets dbg_rejected until the next frame starts.
- R4: 0x02 takes a 16-bit address MSB first and then data bytes. The block accepts bursts of up to 64 bytes, and the low six address bits wrap inside the 64-byte page.
- R5: 0x03 takes a 16-bit address and then streams array bytes for as long as CS stays low, with the address wrapping at the end of the array.
- R6: A program or status write whose instruction byte completes fewer than ENABLE_GAP_CLKS clocks after the enabling frame ended is rejected and sets dbg_rejected.
- R7: After a committed program, status bit 0 reads 1 for WRITE_CYCLE_CLKS clocks. During that time, 0x02, 0x03, 0x01 and 0x06 are ignored: SO stays 0 and dbg_rejected is set. 0x05 still works.
- R8: The write-permission latch clears when the write cycle ends.
- R9: 0x01 followed by a byte copies that byte's bits 3:2 into status bits 3:2.
- R10: If CS rises while SCK is high, the pending program is discarded, no write cycle starts and dbg_aborted is set until the next frame starts.
- R11: SI is sampled on the SCK rising edge, most significant bit first. SO changes on the SCK falling edge and is 0 while CS is high.
- R12: A frame that ends with a partial byte commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| dbg_wel | output | 1 | Write-permission latch |
| dbg_busy | output | 1 | Write cycle in progress |
| dbg_rejected | output | 1 | An instruction in this frame was refused |
| dbg_aborted | output | 1 | The last frame ended with SCK high |

## Verification
The end of the write cycle clears busy and the permission latch, and it can fall in the same cycle as a status poll that is reloading the status byte. The bench provokes this by polling status right after a program, while busy is still set, and again after the window has elapsed. It expects 0x03 (or 0x0F with the protect bits set) in the first poll and the latch-free value in the second. A second collision is an enable followed at once by a program: the instruction decode lands inside the gap window. The bench judges it by dbg_rejected and an unchanged array.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDH,
        PH_ADDL,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic cs_lvl;
        logic sck_lvl;
        logic si_lvl;
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
    } pin_ev_t;

    function automatic logic [7:0] pack_status(input logic [1:0] prot,
                                               input logic latch,
                                               input logic busy);
        return {4'b0000, prot, latch, busy};
    endfunction

endpackage

// File: rtl/seeprom_pin_sync.sv
module seeprom_pin_sync
    import seeprom_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    si,
    output pin_ev_t ev
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE_LVL = 3'b100;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] stage [STAGES];
    logic [NPIN-1:0] last;
    logic [NPIN-1:0] cur;

    assign raw = {cs_n, sck, si};

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage[s] <= IDLE_LVL;
                else if (s == 0)
                    stage[s] <= raw;
                else
                    stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign cur = stage[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) last <= IDLE_LVL;
        else     last <= cur;
    end

    always_comb begin
        ev.cs_lvl   = cur[2];
        ev.sck_lvl  = cur[1];
        ev.si_lvl   = cur[0];
        ev.cs_fall  = last[2] & ~cur[2];
        ev.cs_rise  = ~last[2] & cur[2];
        ev.sck_rise = ~last[1] & cur[1];
        ev.sck_fall = last[1] & ~cur[1];
    end

endmodule

// File: rtl/seeprom_timers.sv
module seeprom_timers #(
    parameter int unsigned WRITE_CYCLE_CLKS = 1000000,
    parameter int unsigned ENABLE_GAP_CLKS  = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_busy,
    input  logic start_gap,
    output logic busy,
    output logic gap_ok,
    output logic busy_done
);
    localparam int BW = $clog2(WRITE_CYCLE_CLKS + 1);
    localparam int GW = $clog2(ENABLE_GAP_CLKS + 1);

    logic [BW-1:0] bcnt;
    logic [GW-1:0] gcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            bcnt      <= '0;
            busy_done <= 1'b0;
        end else begin
            busy_done <= 1'b0;
            if (start_busy) begin
                busy <= 1'b1;
                bcnt <= BW'(WRITE_CYCLE_CLKS - 1);
            end else if (busy) begin
                if (bcnt == '0) begin
                    busy      <= 1'b0;
                    busy_done <= 1'b1;
                end else begin
                    bcnt <= bcnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_ok <= 1'b1;
            gcnt   <= '0;
        end else if (start_gap) begin
            gap_ok <= 1'b0;
            gcnt   <= '0;
        end else if (!gap_ok) begin
            if (gcnt == GW'(ENABLE_GAP_CLKS - 1)) gap_ok <= 1'b1;
            else                                  gcnt   <= gcnt + 1'b1;
        end
    end

    // R6
    gap_met_chk: assert property (@(posedge clk) disable iff (rst)
        start_busy |-> gap_ok);

    // R7
    busy_on_chk: assert property (@(posedge clk) disable iff (rst)
        start_busy |=> busy);

endmodule

// File: rtl/seeprom_store.sv
module seeprom_store
    import seeprom_pkg::*;
#(
    parameter int unsigned BYTES = 256,
    parameter int unsigned PAGE  = 64
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               buf_clr,
    input  logic                               buf_we,
    input  logic [$clog2(PAGE)-1:0]            buf_idx,
    input  logic [7:0]                         buf_data,
    input  logic [$clog2(BYTES)-$clog2(PAGE)-1:0] page_sel,
    input  logic                               commit,
    input  logic [$clog2(BYTES)-1:0]           rd_idx,
    output logic [7:0]                         rd_data
);
    localparam int AW  = $clog2(BYTES);
    localparam int PW  = $clog2(PAGE);
    localparam int PGW = AW - PW;

    logic [7:0]      mem  [BYTES];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pmask;

    always_ff @(posedge clk) begin
        if (rst || buf_clr)
            pmask <= '0;
        else if (buf_we)
            pmask[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < int'(BYTES); j++) begin
            if (rst)
                mem[j] <= ERASED_BYTE;
            else if (commit && (PGW'(j / int'(PAGE)) == page_sel) && pmask[j % int'(PAGE)])
                mem[j] <= pbuf[j % int'(PAGE)];
        end
    end

    assign rd_data = mem[rd_idx];

    // R4
    commit_mask_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> (pmask != '0));

endmodule

// File: rtl/spi_eeprom_responder.sv
module spi_eeprom_responder
    import seeprom_pkg::*;
#(
    parameter int unsigned ARRAY_BYTES      = 256,
    parameter int unsigned PAGE_BYTES       = 64,
    parameter int unsigned WRITE_CYCLE_CLKS = 1000000,
    parameter int unsigned ENABLE_GAP_CLKS  = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    output logic so,
    output logic dbg_wel,
    output logic dbg_busy,
    output logic dbg_rejected,
    output logic dbg_aborted
);
    localparam int AW  = $clog2(ARRAY_BYTES);
    localparam int PW  = $clog2(PAGE_BYTES);
    localparam int PGW = AW - PW;

    pin_ev_t ev;

    phase_e         phase;
    logic [7:0]     opcode;
    logic [2:0]     bitcnt;
    logic [6:0]     shreg;
    logic [7:0]     addr_hi;
    logic           op_ok;
    logic           has_data;
    logic [7:0]     obuf;
    logic           so_r;
    logic [AW-1:0]  rd_ptr;
    logic [PW-1:0]  wr_off;
    logic [PGW-1:0] page_sel;
    logic           wel;
    logic [1:0]     prot;
    logic [1:0]     prot_new;
    logic           rejected;
    logic           aborted;

    logic [7:0]     new_byte;
    logic           byte_done;
    logic [AW-1:0]  full_addr;
    logic [AW-1:0]  rd_idx;
    logic [7:0]     rd_data;
    logic [7:0]     status;
    logic           clean_end;
    logic           commit_wren;
    logic           commit_write;
    logic           commit_wrsr;
    logic           busy;
    logic           gap_ok;
    logic           busy_done;
    logic           buf_we;

    seeprom_pin_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .si   (si),
        .ev   (ev)
    );

    seeprom_timers #(
        .WRITE_CYCLE_CLKS (WRITE_CYCLE_CLKS),
        .ENABLE_GAP_CLKS  (ENABLE_GAP_CLKS)
    ) u_timers (
        .clk        (clk),
        .rst        (rst),
        .start_busy (commit_write | commit_wrsr),
        .start_gap  (commit_wren),
        .busy       (busy),
        .gap_ok     (gap_ok),
        .busy_done  (busy_done)
    );

    seeprom_store #(.BYTES(ARRAY_BYTES), .PAGE(PAGE_BYTES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .buf_clr  (ev.cs_fall),
        .buf_we   (buf_we),
        .buf_idx  (wr_off),
        .buf_data (new_byte),
        .page_sel (page_sel),
        .commit   (commit_write),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data)
    );

    assign new_byte  = {shreg, ev.si_lvl};
    assign byte_done = !ev.cs_lvl && ev.sck_rise && (bitcnt == 3'd7);
    assign full_addr = AW'({addr_hi, new_byte});
    assign rd_idx    = (phase == PH_ADDL) ? full_addr : rd_ptr;
    assign status    = pack_status(prot, wel, busy);
    assign buf_we    = byte_done && (phase == PH_DATA) && (opcode == OP_WRITE);

    assign clean_end    = ev.cs_rise && !ev.sck_lvl && (bitcnt == 3'd0)
                          && (phase == PH_DATA) && op_ok;
    assign commit_wren  = clean_end && (opcode == OP_WREN);
    assign commit_write = clean_end && (opcode == OP_WRITE) && has_data;
    assign commit_wrsr  = clean_end && (opcode == OP_WRSR) && has_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_CMD;
            opcode   <= '0;
            bitcnt   <= '0;
            shreg    <= '0;
            addr_hi  <= '0;
            op_ok    <= 1'b0;
            has_data <= 1'b0;
            obuf     <= '0;
            so_r     <= 1'b0;
            rd_ptr   <= '0;
            wr_off   <= '0;
            page_sel <= '0;
            prot     <= '0;
            prot_new <= '0;
            rejected <= 1'b0;
            aborted  <= 1'b0;
        end else begin
            if (ev.cs_lvl) so_r <= 1'b0;

            if (ev.cs_fall) begin
                phase    <= PH_CMD;
                bitcnt   <= '0;
                op_ok    <= 1'b0;
                has_data <= 1'b0;
                obuf     <= '0;
                rejected <= 1'b0;
                aborted  <= 1'b0;
            end else if (!ev.cs_lvl && ev.sck_rise) begin
                shreg  <= new_byte[6:0];
                bitcnt <= bitcnt + 1'b1;
                if (byte_done) begin
                    unique case (phase)
                        PH_CMD: begin
                            opcode <= new_byte;
                            case (new_byte)
                                OP_RDSR: begin
                                    op_ok <= 1'b1;
                                    phase <= PH_DATA;
                                    obuf  <= status;
                                end
                                OP_READ: begin
                                    if (busy) begin
                                        rejected <= 1'b1;
                                        phase    <= PH_SKIP;
                                    end else begin
                                        op_ok <= 1'b1;
                                        phase <= PH_ADDH;
                                    end
                                end
                                OP_WRITE, OP_WRSR: begin
                                    if (busy || !wel || !gap_ok) begin
                                        rejected <= 1'b1;
                                        phase    <= PH_SKIP;
                                    end else begin
                                        op_ok <= 1'b1;
                                        phase <= (new_byte == OP_WRITE) ? PH_ADDH : PH_DATA;
                                    end
                                end
                                OP_WREN: begin
                                    if (busy) begin
                                        rejected <= 1'b1;
                                        phase    <= PH_SKIP;
                                    end else begin
                                        op_ok <= 1'b1;
                                        phase <= PH_DATA;
                                    end
                                end
                                default: phase <= PH_SKIP;
                            endcase
                        end
                        PH_ADDH: begin
                            addr_hi <= new_byte;
                            phase   <= PH_ADDL;
                        end
                        PH_ADDL: begin
                            phase <= PH_DATA;
                            if (opcode == OP_READ) begin
                                obuf   <= rd_data;
                                rd_ptr <= full_addr + 1'b1;
                            end else begin
                                wr_off   <= full_addr[PW-1:0];
                                page_sel <= full_addr[AW-1:PW];
                            end
                        end
                        PH_DATA: begin
                            case (opcode)
                                OP_READ: begin
                                    obuf   <= rd_data;
                                    rd_ptr <= rd_ptr + 1'b1;
                                end
                                OP_RDSR: obuf <= status;
                                OP_WRITE: begin
                                    wr_off   <= wr_off + 1'b1;
                                    has_data <= 1'b1;
                                end
                                OP_WRSR: begin
                                    if (!has_data) prot_new <= new_byte[3:2];
                                    has_data <= 1'b1;
                                end
                                default: ;
                            endcase
                        end
                        default: ;
                    endcase
                end
            end else if (!ev.cs_lvl && ev.sck_fall) begin
                so_r <= obuf[7];
                obuf <= {obuf[6:0], 1'b0};
            end

            if (ev.cs_rise) begin
                aborted <= ev.sck_lvl;
                if (commit_wrsr) prot <= prot_new;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              wel <= 1'b0;
        else if (commit_wren) wel <= 1'b1;
        else if (busy_done)   wel <= 1'b0;
    end

    assign so           = so_r;
    assign dbg_wel      = wel;
    assign dbg_busy     = busy;
    assign dbg_rejected = rejected;
    assign dbg_aborted  = aborted;

    // R8
    wel_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |=> !wel);

    // R11
    so_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ev.cs_lvl |=> !so);

    // R3
    write_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wel);

    // R10
    abort_no_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.cs_rise && ev.sck_lvl) |=> !$rose(busy));

    // R7
    busy_read_block_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == PH_CMD && busy && new_byte == OP_READ) |=> (phase == PH_SKIP));

endmodule

// File: tb/tb_spi_eeprom_responder.sv
`timescale 1ns/1ps
module tb_spi_eeprom_responder;

    localparam int GAP  = 600;
    localparam int WCYC = 1500;
    localparam int H    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, dbg_wel, dbg_busy, dbg_rejected, dbg_aborted;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0] tx [0:71];
    logic [7:0] rx [0:71];
    logic [7:0] wdata [0:63];
    logic [7:0] model [0:255];
    logic [1:0] m_prot = 2'b00;
    logic [7:0] st;

    always #2.5 clk = ~clk;

    spi_eeprom_responder #(
        .ARRAY_BYTES      (256),
        .PAGE_BYTES       (64),
        .WRITE_CYCLE_CLKS (WCYC),
        .ENABLE_GAP_CLKS  (GAP)
    ) dut (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .sck          (sck),
        .si           (si),
        .so           (so),
        .dbg_wel      (dbg_wel),
        .dbg_busy     (dbg_busy),
        .dbg_rejected (dbg_rejected),
        .dbg_aborted  (dbg_aborted)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc >= 190000 && !done) begin
            done = 1'b1;
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status(input logic latch, input logic busy);
        return {4'b0000, m_prot, latch, busy};
    endfunction

    task automatic xfer(input int nbytes, input int extra, input bit abort_high);
        cs_n = 1'b0;
        tick(H);
        for (int b = 0; b < nbytes; b++) begin
            for (int k = 7; k >= 0; k--) begin
                sck = 1'b0;
                si  = tx[b][k];
                tick(H);
                rx[b][k] = so;
                sck = 1'b1;
                tick(H);
            end
        end
        for (int e = 0; e < extra; e++) begin
            sck = 1'b0;
            si  = 1'b0;
            tick(H);
            sck = 1'b1;
            tick(H);
        end
        if (abort_high) begin
            tick(H);
            cs_n = 1'b1;
            tick(H);
            sck = 1'b0;
            tick(H);
        end else begin
            sck = 1'b0;
            tick(H);
            cs_n = 1'b1;
            tick(2*H);
        end
        si = 1'b0;
    endtask

    task automatic rdsr(output logic [7:0] s);
        tx[0] = 8'h05;
        tx[1] = 8'h00;
        xfer(2, 0, 1'b0);
        s = rx[1];
    endtask

    task automatic wren();
        tx[0] = 8'h06;
        xfer(1, 0, 1'b0);
    endtask

    task automatic do_write(input logic [15:0] addr, input int n, input int extra, input bit abort_high);
        tx[0] = 8'h02;
        tx[1] = addr[15:8];
        tx[2] = addr[7:0];
        for (int i = 0; i < n; i++) tx[3+i] = wdata[i];
        xfer(3 + n, extra, abort_high);
    endtask

    task automatic model_write(input logic [7:0] addr, input int n);
        for (int i = 0; i < n; i++) begin
            logic [5:0] off;
            off = addr[5:0] + 6'(i);
            model[{addr[7:6], off}] = wdata[i];
        end
    endtask

    task automatic read_check(input logic [7:0] addr, input int n, input string req, input bit expect_zero);
        tx[0] = 8'h03;
        tx[1] = 8'h00;
        tx[2] = addr;
        for (int i = 0; i < n; i++) tx[3+i] = 8'h00;
        xfer(3 + n, 0, 1'b0);
        for (int i = 0; i < n; i++) begin
            logic [7:0] a;
            a = addr + 8'(i);
            chk(req, rx[3+i], expect_zero ? 8'h00 : model[a]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;

        tick(10);
        rst = 1'b0;
        tick(5);

        // R1 reset state at the ports
        chk("R1 so", so, 0);
        chk("R1 flags", {dbg_wel, dbg_busy, dbg_rejected, dbg_aborted}, 0);
        rdsr(st);
        chk("R1 R2 status", st, exp_status(0, 0));
        read_check(8'h10, 4, "R1 R5 erased", 1'b0);
        chk("R11 so idle", so, 0);

        // R3 program without the latch
        for (int i = 0; i < 4; i++) wdata[i] = 8'h5A + 8'(i);
        do_write(16'h0010, 4, 0, 1'b0);
        chk("R3 rejected", dbg_rejected, 1);
        read_check(8'h10, 4, "R3 unchanged", 1'b0);

        // R2 latch set, R6 program too soon
        wren();
        rdsr(st);
        chk("R2 latch", st, exp_status(1, 0));
        do_write(16'h0010, 4, 0, 1'b0);
        chk("R6 rejected", dbg_rejected, 1);
        read_check(8'h10, 4, "R6 unchanged", 1'b0);

        // R4 64-byte burst with page wrap
        tick(GAP + 100);
        for (int i = 0; i < 64; i++) wdata[i] = 8'($urandom);
        do_write(16'h0050, 64, 0, 1'b0);
        model_write(8'h50, 64);
        rdsr(st);
        chk("R7 busy status", st, exp_status(1, 1));
        read_check(8'h40, 2, "R7 read ignored", 1'b1);
        chk("R7 rejected", dbg_rejected, 1);
        tick(WCYC + 500);
        rdsr(st);
        chk("R8 latch cleared", st, exp_status(0, 0));
        read_check(8'h40, 64, "R4 R5 burst", 1'b0);

        // R5 read wrap at array end, R4 page wrap at top page
        wren();
        tick(GAP + 100);
        for (int i = 0; i < 4; i++) wdata[i] = 8'($urandom);
        do_write(16'h00FE, 4, 0, 1'b0);
        model_write(8'hFE, 4);
        tick(WCYC + 500);
        read_check(8'hFC, 8, "R5 array wrap", 1'b0);
        read_check(8'hC0, 2, "R4 page wrap", 1'b0);

        // R10 abort with SCK high
        wren();
        tick(GAP + 100);
        wdata[0] = 8'h11; wdata[1] = 8'h22;
        do_write(16'h0020, 2, 0, 1'b1);
        chk("R10 aborted flag", dbg_aborted, 1);
        chk("R10 no busy", dbg_busy, 0);
        rdsr(st);
        chk("R10 status", st, exp_status(1, 0));
        read_check(8'h20, 2, "R10 unchanged", 1'b0);

        // R12 partial trailing byte
        do_write(16'h0020, 2, 7, 1'b0);
        rdsr(st);
        chk("R12 status", st, exp_status(1, 0));
        read_check(8'h20, 2, "R12 unchanged", 1'b0);

        // R9 protect bits
        tx[0] = 8'h01;
        tx[1] = 8'h0C;
        xfer(2, 0, 1'b0);
        m_prot = 2'b11;
        rdsr(st);
        chk("R9 R7 status busy", st, exp_status(1, 1));
        tick(WCYC + 500);
        rdsr(st);
        chk("R9 R8 status after", st, exp_status(0, 0));
        chk("R11 so idle end", so, 0);

        // random programs and reads
        for (int it = 0; it < 6; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 8);
            wren();
            rdsr(st);
            chk("R2 random latch", st, exp_status(1, 0));
            tick(GAP + 100);
            for (int i = 0; i < n; i++) wdata[i] = 8'($urandom);
            do_write({8'h00, a}, n, 0, 1'b0);
            model_write(a, n);
            tick(WCYC + 500);
            read_check(a, n, "R4 R5 random", 1'b0);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule